// File: doc/BRIEF.md
# Parallel LSB-First Lane Scrambler

This block whitens the data of one serial lane before it reaches the serializer. Each clock it can accept one parallel word of `DATA_W` bits, in which bit 0 is the first bit on the wire. Every bit of the word is XORed with one bit of an additive keystream. A 15-bit LFSR with feedback polynomial x^15 + x + 1 produces that keystream. The result is registered and presented one clock later with a valid flag.

The LFSR is oriented so that its bit 0 always holds the keystream bit for the next bit on the wire. One serial step moves every state bit one place toward bit 0 and puts the XOR of bits 1 and 0 into bit 14. The block unrolls `DATA_W` such steps in combinational logic each clock. Bit j of a word therefore uses bit 0 of the state after j steps, and the state after `DATA_W` steps is loaded into the register.

Scrambling is additive, so a second instance with the same seed, fed in word lockstep, recovers the original data. Widths below 15 and an all-zero seed are rejected at elaboration.

Top module: `lane_scrambler`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` become 0 and the LFSR state is reloaded with `SEED_INIT`. The first word accepted after reset uses `SEED_INIT` as its current state.
- R2: Output bit 0 of an accepted word equals input bit 0 XOR bit 0 of the LFSR state current when the word is accepted.
- R3: Output bit j (0 < j < DATA_W) equals input bit j XOR bit 0 of the state after j serial steps. One step maps state s to {s[1]^s[0], s[14:1]}. The rule holds for every DATA_W of 15 or more, including 16 and 64.
- R4: Each accepted word advances the state by exactly DATA_W serial steps, so consecutive accepted words use one unbroken keystream.
- R5: `out_valid` equals the `in_valid` of the previous clock, and the data of an accepted word appears on `out_data` exactly one clock after acceptance.
- R6: In a cycle where `in_valid` is low, `out_data` keeps its value and the state does not advance. The next accepted word continues the keystream where it stopped.
- R7: An all-zero accepted word produces the raw keystream bits on `out_data`. An all-ones word produces their complement.
- R8: A second scrambler with the same seed, fed with `out_data` and `out_valid`, returns the original words one further clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word on `in_data` is accepted this clock |
| in_data | input | DATA_W | Parallel word, bit 0 serialized first |
| out_valid | output | 1 | `out_data` carries a newly scrambled word |
| out_data | output | DATA_W | Registered scrambled word |

## Verification
The bench targets the orientation of the keystream. A design that shifts the LFSR the wrong way, or taps the wrong end, fails the all-zero words, because they expose the raw keystream bit by bit. Gaps in `in_valid` between words catch a state that advances while idle, which shows up as a keystream skip on the next word. A step count that is off by one only shows after the first word, so long runs of back-to-back words are checked at widths 16 and 64. A mid-run reset confirms that the seed is reloaded. A chained second instance confirms that the scrambling can be undone, which a non-additive or misaligned keystream would break.

// File: rtl/lane_scr_pkg.sv
package lane_scr_pkg;

    localparam int LFSR_W = 15;

    typedef logic [LFSR_W-1:0] lfsr_state_t;

    // One serial step: shift toward bit 0, bits 1 and 0 feed bit 14.
    function automatic lfsr_state_t lfsr_step(input lfsr_state_t s);
        return {s[1] ^ s[0], s[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/lane_scr_unroll.sv
module lane_scr_unroll
    import lane_scr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  lfsr_state_t       cur_state,
    output logic [DATA_W-1:0] keystream,
    output lfsr_state_t       next_state
);

    lfsr_state_t chain [DATA_W+1];

    assign chain[0] = cur_state;

    for (genvar j = 0; j < DATA_W; j++) begin : g_step
        assign keystream[j] = chain[j][0];
        assign chain[j+1]   = lfsr_step(chain[j]);
    end

    assign next_state = chain[DATA_W];

endmodule

// File: rtl/lane_scr_state.sv
module lane_scr_state
    import lane_scr_pkg::*;
#(
    parameter lfsr_state_t SEED_INIT = 15'h7FFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    input  lfsr_state_t next_state,
    output lfsr_state_t cur_state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= SEED_INIT;
        end else if (advance) begin
            cur_state <= next_state;
        end
    end

    // R6: no advance while idle
    a_r6_state_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(cur_state));

    // R1: seed reload, state never locks up at zero
    a_r1_seed_load: assert property (@(posedge clk)
        rst |=> cur_state == SEED_INIT);
    a_r1_nonzero: assert property (@(posedge clk) disable iff (rst)
        cur_state != '0);

endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler
    import lane_scr_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter lfsr_state_t SEED_INIT = 15'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    if (DATA_W < LFSR_W) begin : g_width_bad
        $error("lane_scrambler: DATA_W must be at least 15");
    end
    if (SEED_INIT == '0) begin : g_seed_bad
        $error("lane_scrambler: SEED_INIT must be nonzero");
    end

    lfsr_state_t       cur_state;
    lfsr_state_t       next_state;
    logic [DATA_W-1:0] keystream;

    lane_scr_state #(
        .SEED_INIT(SEED_INIT)
    ) i_state (
        .clk       (clk),
        .rst       (rst),
        .advance   (in_valid),
        .next_state(next_state),
        .cur_state (cur_state)
    );

    lane_scr_unroll #(
        .DATA_W(DATA_W)
    ) i_unroll (
        .cur_state (cur_state),
        .keystream (keystream),
        .next_state(next_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data ^ keystream;
            end
        end
    end

    // R5: valid flag follows in_valid one clock later
    a_r5_valid_set: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r5_valid_clr: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: output data held while idle
    a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R2: first wire bit uses bit 0 of the current state
    a_r2_first_bit: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_data[0] == ($past(in_data[0]) ^ $past(cur_state[0])));

    // R1: outputs cleared after a reset edge
    a_r1_out_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/test_lane_scrambler.sv
`timescale 1ns/1ps
module test_lane_scrambler;

    localparam logic [14:0] SEED = 15'h7FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in16 = '0;
    logic [63:0] in64 = '0;
    logic        v16, v64, vrx;
    logic [15:0] o16, orx;
    logic [63:0] o64;

    int total = 0;
    int bad = 0;

    logic [14:0] m16, m64;
    logic [15:0] exp16, exprx;
    logic [63:0] exp64;
    logic        prev_v;
    logic [15:0] prev_d;

    always #2 clk = ~clk;

    lane_scrambler #(.DATA_W(16), .SEED_INIT(SEED)) i_lane_scrambler (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in16),
        .out_valid(v16), .out_data(o16));

    lane_scrambler #(.DATA_W(64), .SEED_INIT(SEED)) i_lane_scrambler_w64 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in64),
        .out_valid(v64), .out_data(o64));

    lane_scrambler #(.DATA_W(16), .SEED_INIT(SEED)) i_lane_scrambler_rx (
        .clk(clk), .rst(rst), .in_valid(v16), .in_data(o16),
        .out_valid(vrx), .out_data(orx));

    // bit-serial reference: keystream bits for w steps
    function automatic logic [63:0] ref_ks(input logic [14:0] s, input int w);
        logic [63:0] k = '0;
        for (int j = 0; j < w; j++) begin
            k[j] = s[0];
            s = {s[1] ^ s[0], s[14:1]};
        end
        return k;
    endfunction

    function automatic logic [14:0] ref_adv(input logic [14:0] s, input int w);
        for (int j = 0; j < w; j++) s = {s[1] ^ s[0], s[14:1]};
        return s;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 valid16", {63'd0, v16}, 64'd0);
        check("R1 data16", {48'd0, o16}, 64'd0);
        check("R1 data64", o64, 64'd0);
        check("R1 rx", {47'd0, vrx, orx}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        m16 = SEED; m64 = SEED;
        exp16 = '0; exp64 = '0; exprx = '0;
        prev_v = 1'b0; prev_d = '0;
    endtask

    // tag: requirement tag for data checks on this word
    task automatic apply(input logic v, input logic [15:0] d16, input logic [63:0] d64,
                         input string tag);
        @(negedge clk);
        in_valid = v; in16 = d16; in64 = d64;
        @(posedge clk);
        #1;
        if (prev_v) exprx = prev_d;
        if (v) begin
            exp16 = d16 ^ ref_ks(m16, 16)[15:0];
            exp64 = d64 ^ ref_ks(m64, 64);
            m16 = ref_adv(m16, 16);
            m64 = ref_adv(m64, 64);
        end
        check({tag, " w16"}, {48'd0, o16}, {48'd0, exp16});
        check({tag, " w64"}, o64, exp64);
        check("R5 valid", {62'd0, v16, v64}, {62'd0, v, v});
        check("R8 rx valid", {63'd0, vrx}, {63'd0, prev_v});
        check("R8 rx data", {48'd0, orx}, {48'd0, exprx});
        prev_v = v; prev_d = d16;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R2/R7: first word zeros -> raw keystream from seed
        apply(1'b1, 16'h0000, 64'd0, "R7 R2 zeros");
        apply(1'b1, 16'hFFFF, '1, "R7 ones");
        // R4: back-to-back zero words continue the sequence
        for (int i = 0; i < 40; i++) apply(1'b1, 16'h0000, 64'd0, "R4 stream");
        // R6: idle gaps hold output and state
        apply(1'b0, 16'hABCD, 64'h1234_5678_9ABC_DEF0, "R6 idle");
        apply(1'b0, 16'h5555, 64'h0F0F, "R6 idle");
        apply(1'b1, 16'h0000, 64'd0, "R6 resume");
        // R3: random data with random gaps
        for (int i = 0; i < 400; i++) begin
            apply(($urandom % 4) != 0, 16'($urandom), {$urandom, $urandom}, "R3 random");
        end
        // R1: mid-run reset restarts from seed
        do_reset();
        apply(1'b1, 16'h0000, 64'd0, "R1 R2 after reset");
        for (int i = 0; i < 50; i++) apply(1'b1, 16'($urandom), {$urandom, $urandom}, "R3 R4 burst");
        apply(1'b0, 16'h0, 64'd0, "R6 tail");
        apply(1'b0, 16'h0, 64'd0, "R8 drain");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule